// File: doc/BRIEF.md
# Bi-Quinary Decade Counter Stage

This block is one decimal digit of a gated event counter. It keeps its count as a single toggle bit followed by a five-position ring counter. The toggle bit halves the rate of the counted events. Each time the toggle bit wraps from one back to zero, the ring moves one position. The ring position and the toggle bit together give a count from zero to nine.

The block samples a single-bit event input on the system clock. It counts each rising transition of that input, but only while the gate-enable input is high. An encoder turns the ring position and the toggle bit into a BCD digit for readout, using digit = 2 × position + toggle. When the digit wraps from nine to zero, the block emits a one-cycle carry pulse, which clocks the next decade of a longer chain.

A synchronous clear input zeroes the stage between measurements. If the ring ever holds a pattern that is not one-hot, the block forces it back to position zero on the next clock.

Top module: `biq_decade`

## Requirements
- R1: While reset is asserted and right after it is released, `digit_o` is 0 and `carry_o` is 0.
- R2: Each rising transition of `sig_i` that is sampled while `gate_i` is 1 and `clr_i` is 0 increments `digit_o` modulo 10. After N such transitions from a cleared state, `digit_o` equals N mod 10. The digit is BCD, with bit 0 as the least significant bit.
- R3: `carry_o` is high for exactly one clock, in the same cycle that `digit_o` goes from 9 to 0. After N counted transitions from a cleared state, the number of carry pulses equals N div 10.
- R4: While `gate_i` is 0, transitions of `sig_i` are ignored. `digit_o` holds its value and `carry_o` stays 0.
- R5: When `clr_i` is 1 at a clock edge, `digit_o` is 0 and `carry_o` is 0 after that edge. This holds even if a counted transition arrives in the same cycle.
- R6: `sig_i` held high for many cycles counts as a single transition.
- R7: The ring holds exactly one active position at every cycle after reset, and `digit_o` never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_i | input | 1 | Synchronous clear of the stage |
| gate_i | input | 1 | Count enable (gate open) |
| sig_i | input | 1 | Event input; each rising transition is counted |
| digit_o | output | 4 | Current count as a BCD digit |
| carry_o | output | 1 | One-cycle pulse on the 9 to 0 wrap |

## Verification
The bound checker tests several properties on every cycle. It confirms that the ring stays one-hot and the digit stays within BCD range. It confirms that each counted edge advances the digit by one modulo ten, and that a closed gate or a clear leaves the expected digit. It also confirms that a carry pulse lasts a single cycle and coincides with the 9 to 0 wrap. Some behaviours only the bench scenarios can show. These are the cumulative relation between the number of edges and the number of carries across a sweep, that a long high level counts once, and that gating and clearing work correctly across full sequences.

// File: rtl/biq_pkg.sv
package biq_pkg;
  // Number of ring positions in one decade (two counts per position).
  localparam int unsigned RING_POS_DEF = 5;

  // Width of a digit that can hold 2*npos - 1.
  function automatic int unsigned digit_width(input int unsigned npos);
    return $clog2(2 * npos);
  endfunction
endpackage

// File: rtl/biq_edge_detect.sv
module biq_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;
  logic sig_d;

  always_comb begin
    sig_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_d;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/biq_toggle_stage.sv
module biq_toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output logic tog_o,
  output logic adv_o
);
  logic tog_q;
  logic tog_d;

  always_comb begin
    tog_d = tog_q;
    if (clr_i)       tog_d = 1'b0;
    else if (step_i) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign tog_o = tog_q;
  // Divide-by-two output: the ring advances when the toggle wraps 1 -> 0.
  assign adv_o = step_i & tog_q & ~clr_i;
endmodule

// File: rtl/biq_ring_stage.sv
module biq_ring_stage #(
  parameter int unsigned NPOS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            adv_i,
  output logic [NPOS-1:0] ring_o,
  output logic            wrap_o
);
  logic [NPOS-1:0] ring_q;
  logic [NPOS-1:0] ring_d;
  logic [NPOS-1:0] rotated;
  logic            legal;

  // Rotate one position towards the high end; the top position wraps to 0.
  generate
    if (NPOS > 1) begin : g_rot
      assign rotated = {ring_q[NPOS-2:0], ring_q[NPOS-1]};
    end else begin : g_one
      assign rotated = ring_q;
    end
  endgenerate

  assign legal = ($countones(ring_q) == 1);

  always_comb begin
    ring_d = ring_q;
    if (clr_i || !legal) ring_d = NPOS'(1);
    else if (adv_i)      ring_d = rotated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= NPOS'(1);
    else        ring_q <= ring_d;
  end

  assign ring_o = ring_q;
  assign wrap_o = adv_i & legal & ring_q[NPOS-1];
endmodule

// File: rtl/biq_bcd_encode.sv
module biq_bcd_encode #(
  parameter int unsigned NPOS = 5,
  parameter int unsigned DW   = 4
) (
  input  logic [NPOS-1:0] ring_i,
  input  logic            tog_i,
  output logic [DW-1:0]   digit_o
);
  logic [DW-1:0] base;

  // digit = 2 * position + toggle; a pattern that is not one-hot reads as 0.
  always_comb begin
    base = '0;
    if ($countones(ring_i) == 1) begin
      for (int i = 0; i < NPOS; i++) begin
        if (ring_i[i]) base = DW'(2 * i);
      end
    end
    digit_o = base | DW'(tog_i);
  end
endmodule

// File: rtl/biq_decade.sv
module biq_decade #(
  parameter int unsigned NPOS = biq_pkg::RING_POS_DEF,
  localparam int unsigned DW  = biq_pkg::digit_width(NPOS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          gate_i,
  input  logic          sig_i,
  output logic [DW-1:0] digit_o,
  output logic          carry_o
);
  logic            rise;
  logic            step;
  logic            tog;
  logic            adv;
  logic [NPOS-1:0] ring;
  logic            wrap;
  logic            carry_q;
  logic            carry_d;

  biq_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(sig_i), .rise_o(rise)
  );

  assign step = rise & gate_i;

  biq_toggle_stage u_tog (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .step_i(step),
    .tog_o(tog), .adv_o(adv)
  );

  biq_ring_stage #(.NPOS(NPOS)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .adv_i(adv),
    .ring_o(ring), .wrap_o(wrap)
  );

  biq_bcd_encode #(.NPOS(NPOS), .DW(DW)) u_enc (
    .ring_i(ring), .tog_i(tog), .digit_o(digit_o)
  );

  always_comb begin
    carry_d = wrap & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/biq_decade_chk.sv
module biq_decade_chk #(
  parameter int unsigned NPOS = 5,
  parameter int unsigned DW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_i,
  input logic            gate_i,
  input logic            rise,
  input logic [NPOS-1:0] ring,
  input logic [DW-1:0]   digit_o,
  input logic            carry_o
);
  localparam logic [DW-1:0] TOP = DW'(2 * NPOS - 1);

  assert_ring_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring) == 1);

  assert_digit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    digit_o <= TOP);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && gate_i && !clr_i) |=>
      digit_o == (($past(digit_o) == TOP) ? '0 : $past(digit_o) + 1'b1));

  assert_carry_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o);

  assert_carry_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry_o) |-> (digit_o == '0 && $past(digit_o) == TOP));

  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_i && !clr_i) |=> ($stable(digit_o) && !carry_o));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (digit_o == '0 && !carry_o));
endmodule

bind biq_decade biq_decade_chk #(.NPOS(NPOS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .gate_i(gate_i), .rise(rise),
  .ring(ring), .digit_o(digit_o), .carry_o(carry_o)
);

// File: tb/sim_biq_decade.sv
module sim_biq_decade;
  logic       clk;
  logic       rst_n;
  logic       clr_i;
  logic       gate_i;
  logic       sig_i;
  logic [3:0] digit_o;
  logic       carry_o;

  int checks;
  int fails;
  int carry_cnt;
  logic carry_prev;

  biq_decade u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .gate_i(gate_i),
    .sig_i(sig_i), .digit_o(digit_o), .carry_o(carry_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Carry monitor: counts pulses and flags a pulse longer than one cycle (R3).
  always @(negedge clk) begin
    if (!rst_n) begin
      carry_prev <= 1'b0;
    end else begin
      if (carry_o) carry_cnt = carry_cnt + 1;
      if (carry_o && carry_prev) begin
        fails = fails + 1;
        $display("FAIL R3: carry high two cycles, actual=1 expected=0");
      end
      carry_prev <= carry_o;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) sig_i = 1'b1;
    @(negedge clk) sig_i = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk) clr_i = 1'b1;
    @(negedge clk) clr_i = 1'b0;
  endtask

  initial begin
    #1500000;
    fails = fails + 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    checks = 0; fails = 0; carry_cnt = 0;
    rst_n = 1'b0; clr_i = 1'b0; gate_i = 1'b1; sig_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 digit in reset", int'(digit_o), 0);
    chk("R1 carry in reset", int'(carry_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 digit after reset", int'(digit_o), 0);
    chk("R1 carry after reset", int'(carry_o), 0);

    // R2 / R3 sweep: N edges from a cleared state
    for (int n = 0; n <= 25; n++) begin
      do_clear();
      base = carry_cnt;
      for (int k = 0; k < n; k++) pulse();
      @(negedge clk);
      chk($sformatf("R2 digit after %0d edges", n), int'(digit_o), n % 10);
      chk($sformatf("R3 carries after %0d edges", n), carry_cnt - base, n / 10);
    end

    // R4: gate closed ignores edges
    do_clear();
    repeat (3) pulse();
    gate_i = 1'b0;
    base = carry_cnt;
    repeat (12) pulse();
    @(negedge clk);
    chk("R4 digit held with gate closed", int'(digit_o), 3);
    chk("R4 no carry with gate closed", carry_cnt - base, 0);
    gate_i = 1'b1;
    repeat (7) pulse();
    @(negedge clk);
    chk("R3 wrap after reopening gate", int'(digit_o), 0);
    chk("R3 one carry after reopening gate", carry_cnt - base, 1);

    // R5: clear wins over a simultaneous edge
    repeat (4) pulse();
    @(negedge clk) begin sig_i = 1'b1; clr_i = 1'b1; end
    @(negedge clk) begin sig_i = 1'b0; clr_i = 1'b0; end
    chk("R5 clear with simultaneous edge", int'(digit_o), 0);
    pulse();
    @(negedge clk);
    chk("R5 counting resumes after clear", int'(digit_o), 1);

    // R5: clear at 9 produces no carry
    do_clear();
    repeat (9) pulse();
    base = carry_cnt;
    do_clear();
    @(negedge clk);
    chk("R5 clear from 9 digit", int'(digit_o), 0);
    chk("R5 clear from 9 no carry", carry_cnt - base, 0);

    // R6: a long high level counts once
    do_clear();
    @(negedge clk) sig_i = 1'b1;
    repeat (8) @(negedge clk);
    sig_i = 1'b0;
    @(negedge clk);
    chk("R6 held level counts once", int'(digit_o), 1);

    // R7: digit never leaves BCD range across a long run
    do_clear();
    for (int k = 0; k < 40; k++) begin
      pulse();
      checks = checks + 1;
      if (digit_o > 4'd9) begin
        fails = fails + 1;
        $display("FAIL R7: digit out of range actual=%0d expected<=9", digit_o);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule